// File: doc/BRIEF.md
# Staggered Sink Enable and Precharge Sequencer

This block converts a global "lights off" request and a per-channel on/off mask into one sink-enable line per channel and one shared precharge-enable line for an LED current-sink array. It spreads channel switching over time so that the supply sees one small step per channel instead of one large inrush. Channel `n` switches `n * STEP_CYC` clock cycles after channel 0. A parameter sets the step in clock cycles; at a 100 MHz clock, `STEP_CYC = 2` gives a 20 ns step. The delay applies to switching on and to switching off, so each channel stays lit for exactly as many cycles as the request stayed low.

The precharge line pulls all outputs up while the array is dark. It rises on the clock edge at which the last lit channel goes dark. It falls on the first edge that samples the request low. A three-state machine controls it:

- `ST_PRECHARGE`: dark and precharging.
- `ST_DRIVE`: request low, channels ramping up or lit.
- `ST_DRAIN`: request high, but some enabled channel is still lit or scheduled.

Its transitions are:

| From | To | Condition |
|---|---|---|
| `ST_PRECHARGE` | `ST_DRIVE` | request sampled low |
| `ST_DRIVE` | `ST_DRAIN` | request sampled high while a channel is still pending |
| `ST_DRIVE` | `ST_PRECHARGE` | request sampled high with nothing pending |
| `ST_DRAIN` | `ST_PRECHARGE` | the last pending channel goes dark |
| `ST_DRAIN` | `ST_DRIVE` | request sampled low again |

Current magnitude and per-channel brightness scaling are handled elsewhere. This block only times the enables.

Top module: `led_stagger_seq`

## Requirements
- R1: For a channel whose `chan_on` bit is 1, `sink_en` rises after the first clock edge that samples `lights_off` low for channel 0. For channel `n` it rises `n*STEP_CYC` edges later.
- R2: Turn-off follows the same schedule. After the first edge that samples `lights_off` high, channel 0 goes dark on that edge and channel `n` goes dark `n*STEP_CYC` edges later.
- R3: Every enabled channel is lit for exactly as many cycles as `lights_off` was sampled low. This holds even for a pulse shorter than the whole ramp: a channel not yet lit when `lights_off` rises still turns on and off at its own scheduled times.
- R4: While a channel is within its lit window, `sink_en[n]` equals the live `chan_on[n]` bit. A channel whose bit is 0 is never enabled.
- R5: `precharge_en` falls on the first edge that samples `lights_off` low, whatever the mask.
- R6: `precharge_en` rises on the same edge at which the last enabled channel goes dark. With an all-zero mask it rises on the first edge that samples `lights_off` high.
- R7: `precharge_en` and any `sink_en` bit are never high in the same cycle.
- R8: During and after reset the block is in `ST_PRECHARGE`: `precharge_en` is 1 and all `sink_en` bits are 0.
- R9: If `lights_off` returns low while channels are still draining, `precharge_en` stays 0 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lights_off | input | 1 | 1 requests all channels dark and precharged |
| chan_on | input | N_CH | Per-channel on/off mask |
| sink_en | output | N_CH | Per-channel current-sink enable |
| precharge_en | output | 1 | Common precharge enable |

## Verification
The bench targets three cases.

- **Pulse shorter than the ramp.** A one- or three-cycle low pulse must travel to the highest channel intact. A design that rebuilt the schedule from a counter restarted on each edge would drop the late channels or cut their on-time.
- **Precharge edge placement.** The rise is checked with only the slowest channel enabled, and again with an empty mask. A design that waited for the full ramp would rise late on an empty mask. One that ignored pending channels would overlap precharge with a lit sink.
- **Re-entry while draining.** The request goes low again mid-drain. A design that passed through `ST_PRECHARGE` on the way back would glitch the precharge line.

// File: rtl/stagger_pkg.sv
package stagger_pkg;
    typedef enum logic [1:0] {
        ST_PRECHARGE = 2'd0,
        ST_DRIVE     = 2'd1,
        ST_DRAIN     = 2'd2
    } seq_state_e;
endpackage

// File: rtl/stagger_line.sv
// Delay line of the "lit" request: one bit per clock cycle of the whole ramp.
// Channel n taps the line at n*STEP_CYC, giving an exact delayed copy of the
// request on both edges, however short the request pulse is.
module stagger_line #(
    parameter int N_CH     = 16,
    parameter int STEP_CYC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lights_off,
    input  logic [N_CH-1:0] chan_on,
    output logic [N_CH-1:0] lit,
    output logic [N_CH-1:0] pend_nx
);
    localparam int SPAN = (N_CH - 1) * STEP_CYC + 1;

    logic [SPAN-1:0] hist_q;
    logic [SPAN-1:0] hist_nx;

    generate
        if (SPAN > 1) begin : g_long
            assign hist_nx = {hist_q[SPAN-2:0], ~lights_off};
        end else begin : g_short
            assign hist_nx = ~lights_off;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_nx;
    end

    // A channel is pending after this edge if any part of the line up to its
    // tap still holds a lit sample and the channel is enabled in the mask.
    generate
        for (genvar n = 0; n < N_CH; n++) begin : g_tap
            localparam int TAP = n * STEP_CYC;
            assign lit[n]     = hist_q[TAP];
            assign pend_nx[n] = chan_on[n] & (|hist_nx[TAP:0]);
        end
    endgenerate
endmodule

// File: rtl/precharge_fsm.sv
module precharge_fsm
    import stagger_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lights_off,
    input  logic       any_pend_nx,
    output seq_state_e state_o,
    output logic       precharge_en
);
    seq_state_e st_q, st_nx;

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_PRECHARGE: if (!lights_off) st_nx = ST_DRIVE;
            ST_DRIVE:     if (lights_off)  st_nx = any_pend_nx ? ST_DRAIN : ST_PRECHARGE;
            ST_DRAIN: begin
                if (!lights_off)       st_nx = ST_DRIVE;
                else if (!any_pend_nx) st_nx = ST_PRECHARGE;
            end
            default:                   st_nx = ST_PRECHARGE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_PRECHARGE;
        else        st_q <= st_nx;
    end

    always_comb begin
        state_o      = st_q;
        precharge_en = (st_q == ST_PRECHARGE);
    end

    // R5: a sampled low request removes precharge at that very edge
    p_pre_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !lights_off |=> !precharge_en);

    // R6: precharge only ever rises after the request was sampled high
    p_pre_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(precharge_en) |-> $past(lights_off));
endmodule

// File: rtl/led_stagger_seq.sv
module led_stagger_seq #(
    parameter int N_CH     = 16,
    parameter int STEP_CYC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lights_off,
    input  logic [N_CH-1:0] chan_on,
    output logic [N_CH-1:0] sink_en,
    output logic            precharge_en
);
    import stagger_pkg::*;

    logic [N_CH-1:0] lit;
    logic [N_CH-1:0] pend_nx;
    seq_state_e      state;
    logic            pre;

    stagger_line #(.N_CH(N_CH), .STEP_CYC(STEP_CYC)) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .lights_off (lights_off),
        .chan_on    (chan_on),
        .lit        (lit),
        .pend_nx    (pend_nx)
    );

    precharge_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .lights_off   (lights_off),
        .any_pend_nx  (|pend_nx),
        .state_o      (state),
        .precharge_en (pre)
    );

    always_comb begin
        precharge_en = pre;
        sink_en      = lit & chan_on & {N_CH{~pre}};
    end

    // R7: sinks and precharge are mutually exclusive
    p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        precharge_en |-> (sink_en == '0));

    // R1: channel 0 lights on the first edge that samples the request low
    p_ch0_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(lights_off) && chan_on[0]) |-> sink_en[0]);

    // R2: channel 0 goes dark on the first edge that samples the request high
    p_ch0_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lights_off)) |-> !sink_en[0]);
endmodule

// File: tb/sim_led_stagger_seq.sv
`timescale 1ns/1ps
module sim_led_stagger_seq;
    localparam int N    = 16;
    localparam int STEP = 2;
    localparam int SPAN = (N - 1) * STEP + 1;

    logic         clk = 0;
    logic         rst_n = 0;
    logic         lights_off = 1;
    logic [N-1:0] chan_on = '0;
    logic [N-1:0] sink_en;
    logic         precharge_en;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #5 clk = ~clk;

    led_stagger_seq #(.N_CH(N), .STEP_CYC(STEP)) u0 (
        .clk(clk), .rst_n(rst_n), .lights_off(lights_off),
        .chan_on(chan_on), .sink_en(sink_en), .precharge_en(precharge_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // Request low for w edges with the given mask, then high; check every cycle.
    task automatic run_pulse(input logic [N-1:0] mask, input int w, input string why);
        int lmax = 0;
        for (int n = 0; n < N; n++) if (mask[n]) lmax = n * STEP;
        chan_on    = mask;
        lights_off = 0;
        for (int cyc = 1; cyc <= w + SPAN + 1; cyc++) begin
            logic [N-1:0] exp_s;
            tick();
            exp_s = '0;
            for (int n = 0; n < N; n++)
                if (mask[n] && (cyc - 1 >= n * STEP) && (cyc - 1 < n * STEP + w)) exp_s[n] = 1'b1;
            chk($sformatf("%s %s sink cyc=%0d", why, (cyc <= w) ? "R1" : "R2", cyc),
                {16'b0, sink_en}, {16'b0, exp_s});
            chk($sformatf("%s %s precharge cyc=%0d", why, (cyc <= w) ? "R5" : "R6", cyc),
                {31'b0, precharge_en}, {31'b0, (cyc >= lmax + w + 1)});
            chk("R7 overlap", {31'b0, precharge_en && (|sink_en)}, 32'd0);
            if (cyc == w) lights_off = 1;
        end
    endtask

    // R4: live mask follows while lit
    task automatic mask_live();
        chan_on    = 16'hFFFF;
        lights_off = 0;
        repeat (SPAN + 1) tick();
        chk("R4 all lit", {16'b0, sink_en}, 32'h0000FFFF);
        chan_on = 16'hA5C3;
        #1;
        chk("R4 live mask", {16'b0, sink_en}, 32'h0000A5C3);
        lights_off = 1;
        repeat (SPAN + 2) tick();
        chk("R6 quiet after mask test", {31'b0, precharge_en}, 32'd1);
        chk("R2 dark after mask test", {16'b0, sink_en}, 32'd0);
    endtask

    // R9: request returns low mid-drain; precharge must never pulse
    task automatic reenter_drain();
        chan_on    = 16'hFFFF;
        lights_off = 0;
        repeat (SPAN + 1) tick();
        lights_off = 1;
        repeat (3) tick();
        lights_off = 0;
        for (int cyc = 0; cyc < SPAN + 5; cyc++) begin
            tick();
            chk($sformatf("R9 precharge held off cyc=%0d", cyc), {31'b0, precharge_en}, 32'd0);
        end
        chk("R9 all lit again", {16'b0, sink_en}, 32'h0000FFFF);
        lights_off = 1;
        repeat (SPAN + 2) tick();
        chk("R9 precharge after final drain", {31'b0, precharge_en}, 32'd1);
    endtask

    initial begin
        #1;
        chk("R8 reset precharge", {31'b0, precharge_en}, 32'd1);
        chk("R8 reset sinks", {16'b0, sink_en}, 32'd0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tick();
        chk("R8 idle precharge", {31'b0, precharge_en}, 32'd1);

        run_pulse(16'hFFFF, 40, "full");
        run_pulse(16'h0001, 5,  "ch0 only");
        run_pulse(16'h8000, 6,  "ch15 only");
        run_pulse(16'h0000, 4,  "empty mask");
        run_pulse(16'h5A5A, 35, "sparse");
        run_pulse(16'hFFFF, 1,  "R3 single-cycle");
        run_pulse(16'h8421, 3,  "R3 short");
        mask_live();
        reenter_drain();

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule